// File: doc/BRIEF.md
# Way-Filtered Set-Associative Cache Lookup

This block is the lookup stage of a set-associative cache. Each stored tag has a few of its low-order bits copied into a narrow side array. A request first reads only that side array for its set. It compares the request's low tag bits against every way. A way whose valid bit is clear, or whose low bits differ, cannot hold the requested line: one differing bit already proves a full-tag mismatch. Only the surviving ways receive a read enable for the wide tag and payload arrays, so most ways are never activated.

The lookup is a two-stage pipeline. It takes a new request every cycle.

- **Stage 1** indexes the set and registers the per-way enable mask, along with a count of the enabled ways.
- **Stage 2** reads the full tag and payload of the enabled ways only. It then registers the hit flag, the hit way, the payload and a multi-match error.

The payload width is a parameter, so the same structure serves as a data cache or as a directory cache. Fills write the tag, partial tag, valid bit and payload of a caller-chosen victim way in one cycle. Invalidates clear one valid bit.

The first stage is a two-state machine, `STG_EMPTY` and `STG_LOADED`, with these transitions:

| Transition | From | To | Condition |
|---|---|---|---|
| accept | `STG_EMPTY` | `STG_LOADED` | `req_valid` high |
| stream | `STG_LOADED` | `STG_LOADED` | `req_valid` high |
| drain | `STG_LOADED` | `STG_EMPTY` | `req_valid` low |
| idle | `STG_EMPTY` | `STG_EMPTY` | `req_valid` low |

The second stage classifies each response as `RSP_MISS`, `RSP_HIT` or `RSP_MULTI`.

The parameters must satisfy `PT_W <= TAG_W`.

Top module: `wayfilter_lookup`

## Requirements
- R1: After reset every way of every set is invalid. A lookup made then gives `way_en` = 0, `en_count` = 0 and a miss. While reset is held low, `rsp_valid`, `hit`, `multi_err`, `way_en` and `rd_data` are 0.
- R2: One rising edge after a request is sampled, `way_en[w]` is 1 exactly when way w of the requested set is valid and its stored tag bits [PT_W-1:0] equal `req_tag[PT_W-1:0]`. `en_count` equals the number of ones in `way_en`.
- R3: Two rising edges after a request is sampled, `rsp_valid` is 1 for one cycle carrying that request's result. `rsp_valid` is 0 in any cycle whose second stage held no request.
- R4: When exactly one enabled way holds the full request tag, the response has `hit` = 1, `hit_way` = that way number in binary, and `rd_data` = that way's payload.
- R5: When no enabled way holds the full tag, the response has `hit` = 0, `hit_way` = 0, `rd_data` = 0 and `multi_err` = 0.
- R6: A fill writes the tag, partial tag, valid bit and payload of way `fill_way` in set `fill_index` at one rising edge. A request sampled at the next edge already sees the new contents.
- R7: An invalidate clears the valid bit of way `inv_way` in set `inv_index`. That way is then excluded from `way_en`, even though its partial tag still matches.
- R8: When more than one enabled way holds the full tag, the response has `multi_err` = 1, `hit` = 0 and `rd_data` = 0.
- R9: A way that passes the partial filter but fails the full compare gives a miss while still counting in `en_count`. A way holding the requested tag is never filtered out.
- R10: Requests on consecutive cycles are each answered, in order, with no stall.
- R11: When a fill and an invalidate name the same set and way in the same cycle, the fill wins and the way ends valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_index | input | IDX_W | Set index of the request |
| req_tag | input | TAG_W | Full tag of the request |
| fill_en | input | 1 | Write one way |
| fill_index | input | IDX_W | Set to fill |
| fill_way | input | WAY_W | Victim way to overwrite |
| fill_tag | input | TAG_W | Tag written to the victim way |
| fill_data | input | DATA_W | Payload written to the victim way |
| inv_en | input | 1 | Clear one valid bit |
| inv_index | input | IDX_W | Set to invalidate |
| inv_way | input | WAY_W | Way to invalidate |
| way_en | output | WAYS | Per-way read enable for the wide arrays (stage 1 result) |
| en_count | output | CNT_W | Number of enabled ways |
| rsp_valid | output | 1 | Response present |
| hit | output | 1 | Exactly one full-tag match |
| hit_way | output | WAY_W | Matching way number |
| rd_data | output | DATA_W | Payload of the matching way |
| multi_err | output | 1 | More than one full-tag match |

## Verification
The enable mask and the way count are due one rising edge after a request is sampled. The hit, hit way, payload and error flag are due two rising edges after it. Fills and invalidates take effect at the single edge on which they are sampled.

The bench drives every input on the falling edge. It samples each output on a later falling edge, counting exactly one or two rising edges as the result requires. During the back-to-back table walk, the mask of request c is checked in the same sample as the response of request c-1, so the overlap exercises both pipeline stages at once.

// File: rtl/wayfilter_lookup_pkg.sv
package wayfilter_lookup_pkg;

    // Occupancy of the first pipeline stage
    typedef enum logic {
        STG_EMPTY  = 1'b0,
        STG_LOADED = 1'b1
    } stage_t;

    // Outcome of the full-tag compare over the enabled ways
    typedef enum logic [1:0] {
        RSP_MISS  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_MULTI = 2'd2
    } rsp_kind_t;

endpackage

// File: rtl/wf_ptag_filter.sv
module wf_ptag_filter #(
    parameter int SETS  = 16,
    parameter int WAYS  = 8,
    parameter int PT_W  = 2,
    parameter int IDX_W = $clog2(SETS),
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  logic [WAY_W-1:0] wr_way,
    input  logic [PT_W-1:0]  wr_ptag,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_index,
    input  logic [WAY_W-1:0] inv_way,
    input  logic [IDX_W-1:0] rd_index,
    input  logic [PT_W-1:0]  rd_ptag,
    output logic [WAYS-1:0]  filt_mask
);

    logic [SETS-1:0][WAYS-1:0]           valid_q;
    logic [SETS-1:0][WAYS-1:0][PT_W-1:0] ptag_q;

    // Valid bits: the invalidate is applied first, so a same-slot fill wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en) begin
                valid_q[inv_index][inv_way] <= 1'b0;
            end
            if (wr_en) begin
                valid_q[wr_index][wr_way] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ptag_q[wr_index][wr_way] <= wr_ptag;
        end
    end

    // One narrow comparator per way
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign filt_mask[w] = valid_q[rd_index][w] && (ptag_q[rd_index][w] == rd_ptag);
    end

    // R7
    inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(wr_en && wr_index == inv_index && wr_way == inv_way))
        |=> !valid_q[$past(inv_index)][$past(inv_way)]);

    // R6
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_index)][$past(wr_way)]);

endmodule

// File: rtl/wf_tag_data_array.sv
module wf_tag_data_array #(
    parameter int SETS   = 16,
    parameter int WAYS   = 8,
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SETS),
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_index,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [TAG_W-1:0]             wr_tag,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [WAYS-1:0]              rd_en,
    input  logic [IDX_W-1:0]             rd_index,
    input  logic [TAG_W-1:0]             cmp_tag,
    output logic [WAYS-1:0]              full_match,
    output logic [WAYS-1:0][DATA_W-1:0]  way_data
);

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [DATA_W-1:0] data_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_index][wr_way]  <= wr_tag;
            data_q[wr_index][wr_way] <= wr_data;
        end
    end

    // Each way is a separately enabled bank: a disabled way returns zeros
    for (genvar w = 0; w < WAYS; w++) begin : g_bank
        logic [TAG_W-1:0] tag_rd;
        assign tag_rd        = rd_en[w] ? tag_q[rd_index][w] : '0;
        assign full_match[w] = rd_en[w] && (tag_rd == cmp_tag);
        assign way_data[w]   = rd_en[w] ? data_q[rd_index][w] : '0;
    end

endmodule

// File: rtl/wf_hit_resolve.sv
module wf_hit_resolve
    import wayfilter_lookup_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int DATA_W = 32,
    parameter int WAY_W  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             match,
    input  logic [WAYS-1:0][DATA_W-1:0] way_data,
    output rsp_kind_t                   kind,
    output logic [WAY_W-1:0]            sel_way,
    output logic [DATA_W-1:0]           sel_data
);

    always_comb begin
        sel_way  = '0;
        sel_data = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) begin
                sel_way  = WAY_W'(w);
                sel_data = way_data[w];
            end
        end
        if ($countones(match) == 0) begin
            kind = RSP_MISS;
        end else if ($countones(match) == 1) begin
            kind = RSP_HIT;
        end else begin
            kind = RSP_MULTI;
        end
    end

endmodule

// File: rtl/wayfilter_lookup.sv
module wayfilter_lookup
    import wayfilter_lookup_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int WAYS   = 8,
    parameter int TAG_W  = 12,
    parameter int PT_W   = 2,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(SETS),
    parameter int WAY_W  = $clog2(WAYS),
    parameter int CNT_W  = $clog2(WAYS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_index,
    input  logic [WAY_W-1:0]  inv_way,
    output logic [WAYS-1:0]   way_en,
    output logic [CNT_W-1:0]  en_count,
    output logic              rsp_valid,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] rd_data,
    output logic              multi_err
);

    // ---------------- Stage 1: partial-tag filter ----------------
    stage_t            s1_state, s1_next;
    logic [IDX_W-1:0]  s1_index;
    logic [TAG_W-1:0]  s1_tag;
    logic [WAYS-1:0]   s1_mask;
    logic [CNT_W-1:0]  s1_count;
    logic [WAYS-1:0]   filt_mask;
    logic [CNT_W-1:0]  filt_count;

    wf_ptag_filter #(
        .SETS (SETS),
        .WAYS (WAYS),
        .PT_W (PT_W),
        .IDX_W(IDX_W),
        .WAY_W(WAY_W)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_en),
        .wr_index (fill_index),
        .wr_way   (fill_way),
        .wr_ptag  (fill_tag[PT_W-1:0]),
        .inv_en   (inv_en),
        .inv_index(inv_index),
        .inv_way  (inv_way),
        .rd_index (req_index),
        .rd_ptag  (req_tag[PT_W-1:0]),
        .filt_mask(filt_mask)
    );

    always_comb begin
        filt_count = '0;
        for (int w = 0; w < WAYS; w++) begin
            filt_count = filt_count + CNT_W'(filt_mask[w]);
        end
    end

    // Next-state logic: accept / stream / drain / idle
    always_comb begin
        unique case (s1_state)
            STG_EMPTY:  s1_next = req_valid ? STG_LOADED : STG_EMPTY;
            STG_LOADED: s1_next = req_valid ? STG_LOADED : STG_EMPTY;
            default:    s1_next = STG_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_state <= STG_EMPTY;
        end else begin
            s1_state <= s1_next;
        end
    end

    // Stage 1 payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_index <= '0;
            s1_tag   <= '0;
            s1_mask  <= '0;
            s1_count <= '0;
        end else begin
            s1_mask  <= req_valid ? filt_mask : '0;
            s1_count <= req_valid ? filt_count : '0;
            if (req_valid) begin
                s1_index <= req_index;
                s1_tag   <= req_tag;
            end
        end
    end

    assign way_en   = s1_mask;
    assign en_count = s1_count;

    // ---------------- Stage 2: gated full compare ----------------
    logic [WAYS-1:0]             full_match;
    logic [WAYS-1:0][DATA_W-1:0] way_data;
    rsp_kind_t                   kind;
    logic [WAY_W-1:0]            sel_way;
    logic [DATA_W-1:0]           sel_data;

    wf_tag_data_array #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W),
        .WAY_W (WAY_W)
    ) u_arrays (
        .clk       (clk),
        .wr_en     (fill_en),
        .wr_index  (fill_index),
        .wr_way    (fill_way),
        .wr_tag    (fill_tag),
        .wr_data   (fill_data),
        .rd_en     (s1_mask),
        .rd_index  (s1_index),
        .cmp_tag   (s1_tag),
        .full_match(full_match),
        .way_data  (way_data)
    );

    wf_hit_resolve #(
        .WAYS  (WAYS),
        .DATA_W(DATA_W),
        .WAY_W (WAY_W)
    ) u_resolve (
        .match   (full_match),
        .way_data(way_data),
        .kind    (kind),
        .sel_way (sel_way),
        .sel_data(sel_data)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            hit       <= 1'b0;
            hit_way   <= '0;
            rd_data   <= '0;
            multi_err <= 1'b0;
        end else begin
            rsp_valid <= (s1_state == STG_LOADED);
            hit       <= 1'b0;
            hit_way   <= '0;
            rd_data   <= '0;
            multi_err <= 1'b0;
            if (s1_state == STG_LOADED) begin
                unique case (kind)
                    RSP_HIT: begin
                        hit     <= 1'b1;
                        hit_way <= sel_way;
                        rd_data <= sel_data;
                    end
                    RSP_MULTI: multi_err <= 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    // Mask of the request now in the output register, kept for checking
    logic [WAYS-1:0] mask_d;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_d <= '0;
        end else begin
            mask_d <= s1_mask;
        end
    end

    // R3
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_state == STG_LOADED) |=> rsp_valid);

    // R3
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_state == STG_EMPTY) |=> !rsp_valid);

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (s1_state == STG_LOADED));

    // R4
    hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && hit) |-> mask_d[hit_way]);

    // R8
    multi_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        multi_err |-> (!hit && rd_data == '0));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !hit) |-> (rd_data == '0 && hit_way == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!rsp_valid && !hit && !multi_err && way_en == '0));

endmodule

// File: tb/tb_wayfilter_lookup.sv
module tb_wayfilter_lookup;

    localparam int SETS = 16, WAYS = 8, TAG_W = 12, PT_W = 2, DATA_W = 32;
    localparam int IDX_W = $clog2(SETS), WAY_W = $clog2(WAYS), CNT_W = $clog2(WAYS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [IDX_W-1:0]  req_index = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              fill_en = 1'b0;
    logic [IDX_W-1:0]  fill_index = '0;
    logic [WAY_W-1:0]  fill_way = '0;
    logic [TAG_W-1:0]  fill_tag = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic              inv_en = 1'b0;
    logic [IDX_W-1:0]  inv_index = '0;
    logic [WAY_W-1:0]  inv_way = '0;
    logic [WAYS-1:0]   way_en;
    logic [CNT_W-1:0]  en_count;
    logic              rsp_valid, hit, multi_err;
    logic [WAY_W-1:0]  hit_way;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wayfilter_lookup #(
        .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PT_W(PT_W), .DATA_W(DATA_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
        .req_tag(req_tag), .fill_en(fill_en), .fill_index(fill_index),
        .fill_way(fill_way), .fill_tag(fill_tag), .fill_data(fill_data),
        .inv_en(inv_en), .inv_index(inv_index), .inv_way(inv_way),
        .way_en(way_en), .en_count(en_count), .rsp_valid(rsp_valid), .hit(hit),
        .hit_way(hit_way), .rd_data(rd_data), .multi_err(multi_err)
    );

    // Table: set 3 holds way w with tag w*256 + (w mod 4), payload D0000000 + w
    localparam int N = 7;
    localparam logic [IDX_W-1:0]  T_IDX  [N] = '{4'd3, 4'd3, 4'd3, 4'd3, 4'd3, 4'd5, 4'd3};
    localparam logic [TAG_W-1:0]  T_TAG  [N] = '{12'h000, 12'h401, 12'h703, 12'h302, 12'h202, 12'h000, 12'h501};
    localparam logic [WAYS-1:0]   T_MASK [N] = '{8'h11, 8'h22, 8'h88, 8'h44, 8'h44, 8'h00, 8'h22};
    localparam logic              T_HIT  [N] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [WAY_W-1:0]  T_WAY  [N] = '{3'd0, 3'd0, 3'd7, 3'd0, 3'd2, 3'd0, 3'd5};
    localparam logic [DATA_W-1:0] T_DATA [N] = '{32'hD000_0000, 32'h0, 32'hD000_0007, 32'h0,
                                                 32'hD000_0002, 32'h0, 32'hD000_0005};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill(input int idx, input int way, input logic [TAG_W-1:0] tag,
                        input logic [DATA_W-1:0] data);
        @(negedge clk);
        fill_en = 1'b1; fill_index = IDX_W'(idx); fill_way = WAY_W'(way);
        fill_tag = tag; fill_data = data;
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Caller is at a falling edge; checks the mask after one edge and the response after two
    task automatic lookup(input string req, input int idx, input logic [TAG_W-1:0] tag,
                          input logic [WAYS-1:0] emask, input logic ehit,
                          input logic [WAY_W-1:0] eway, input logic [DATA_W-1:0] edata,
                          input logic eerr);
        req_valid = 1'b1; req_index = IDX_W'(idx); req_tag = tag;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " way_en"}, 64'(way_en), 64'(emask));
        check({req, " en_count"}, 64'(en_count), 64'($countones(emask)));
        @(posedge clk);
        @(negedge clk);
        check({req, " rsp"}, {61'(rd_data), ehit ? hit_way : 3'd0} ^ 64'(0),
              {61'(edata), ehit ? eway : 3'd0});
        check({req, " flags"}, {61'(0), rsp_valid, hit, multi_err}, {61'(0), 1'b1, ehit, eerr});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", {56'(way_en), 3'(0), rsp_valid, hit, multi_err, 2'(0)}, 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        lookup("R1 empty lookup", 3, 12'h000, 8'h00, 1'b0, 3'd0, 32'h0, 1'b0);

        for (int w = 0; w < WAYS; w++) begin
            fill(3, w, TAG_W'(w * 256 + (w % 4)), 32'hD000_0000 + DATA_W'(w));
        end

        // R2 R4 R5 R9 R10: back-to-back table walk
        for (int c = 0; c < N + 2; c++) begin
            if (c < N) begin
                req_valid = 1'b1; req_index = T_IDX[c]; req_tag = T_TAG[c];
            end else begin
                req_valid = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            if (c < N) begin
                check($sformatf("R2 R9 vec%0d way_en", c), 64'(way_en), 64'(T_MASK[c]));
                check($sformatf("R2 vec%0d en_count", c), 64'(en_count), 64'($countones(T_MASK[c])));
            end
            if (c >= 1 && c <= N) begin
                check($sformatf("R10 R3 vec%0d rsp_valid", c - 1), 64'(rsp_valid), 64'(1));
                check($sformatf("R4 R5 vec%0d hit", c - 1), 64'(hit), 64'(T_HIT[c - 1]));
                check($sformatf("R4 vec%0d hit_way", c - 1), 64'(hit_way), 64'(T_WAY[c - 1]));
                check($sformatf("R4 R5 vec%0d rd_data", c - 1), 64'(rd_data), 64'(T_DATA[c - 1]));
                check($sformatf("R8 vec%0d multi_err", c - 1), 64'(multi_err), 64'(0));
            end
        end
        check("R3 idle rsp_valid", 64'(rsp_valid), 64'(0));

        // R7: invalidate way 0 of set 3; way 4 still passes the filter but misses
        @(negedge clk);
        inv_en = 1'b1; inv_index = 4'd3; inv_way = 3'd0;
        @(posedge clk);
        @(negedge clk);
        inv_en = 1'b0;
        lookup("R7 invalidated", 3, 12'h000, 8'h10, 1'b0, 3'd0, 32'h0, 1'b0);

        // R8: duplicate tag in two ways
        fill(9, 1, 12'h055, 32'h11);
        fill(9, 2, 12'h055, 32'h22);
        lookup("R8 multi", 9, 12'h055, 8'h06, 1'b0, 3'd0, 32'h0, 1'b1);

        // R11 R6: fill and invalidate on the same slot, then look up at once
        @(negedge clk);
        fill_en = 1'b1; fill_index = 4'd9; fill_way = 3'd3; fill_tag = 12'h0AA; fill_data = 32'h33;
        inv_en = 1'b1; inv_index = 4'd9; inv_way = 3'd3;
        @(posedge clk);
        @(negedge clk);
        fill_en = 1'b0; inv_en = 1'b0;
        lookup("R11 R6 fill wins", 9, 12'h0AA, 8'h08, 1'b1, 3'd3, 32'h33, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule